// File: doc/BRIEF.md
# Packet Framing Check Controller

This block watches a group of independent 16-bit receive channels. Each channel carries framed packets. A packet opens with a command word that names a destination port. After it come sixteen payload words and one closing check word. The closing word is chosen so that the XOR of all seventeen words is zero. For every channel the controller does five things:

- It recognises the opening word.
- It latches the two-bit destination carried in that word.
- It counts the words of the data phase.
- It folds each of those words into a running XOR.
- It closes the packet once the seventeenth word arrives.

A well-formed packet produces only a start pulse, a destination and an end pulse, so no host processor is needed for it. A count failure, a nonzero residue, or a data word that arrives outside a data phase sets a sticky per-channel flag and raises a shared interrupt. That interrupt stays up until the host acknowledges it.

A synchronous clear returns every channel and the interrupt to the idle state. Output multiplexing and any host register access sit outside this block.

Top module: `pkt_frame_chk`

## Requirements
- R1: On channel c, a word is a command word when `cvalid_i[c]` is 1 and bit 15 of the word is 0. The state of `dvalid_i[c]` does not matter for this. A command word is accepted in any state, and `pkt_start_o[c]` is 1 for the one cycle after the accepting edge. A word with `cvalid_i` set and bit 15 equal to 1 is not a command.
- R2: `dest_o[2c+1:2c]` takes bits [1:0] of the last accepted command word in the cycle after it is accepted, and holds that value until the next command or a clear.
- R3: A data word is a word with `dvalid_i[c]` set that is not a command word, which includes a word with `cvalid_i` set and bit 15 equal to 1. Only data words that arrive during a data phase are counted and XORed.
- R4: The 17th data word after a command closes the packet. `pkt_end_o[c]` is 1 for exactly the one cycle after the edge that sampled that word. A packet whose 17 words XOR to zero sets no flag and raises no interrupt.
- R5: When the XOR of the 17 data-phase words is not zero, `chk_err_o[c]` becomes 1 in the cycle after the 17th word.
- R6: A command word that arrives while a data phase holds fewer than 17 words sets `cnt_err_o[c]`, emits no end pulse, and starts a new packet as R1 and R2 describe, with the count and the XOR restarted.
- R7: A data word that arrives outside a data phase (before any command, or after a packet has closed) sets `frm_err_o[c]` and is discarded. It causes no start, no end and no change of destination.
- R8: `irq_o` becomes 1 in the cycle after any error event on any channel. It stays at 1 until an edge with `irq_ack_i` at 1 and no new event on that edge, after which it is 0. If an event and an acknowledge arrive on the same edge, the event wins.
- R9: The error flags are sticky. Neither an acknowledge nor later traffic clears them; only a clear or a reset does.
- R10: `clr_i`, sampled on a clock edge, zeroes every flag, pulse, destination, counter, accumulator and the interrupt, and returns every channel to idle.
- R11: Channels are independent. Channel c uses word bits [16c+15:16c] and bit c of every per-channel vector, and traffic on one channel never changes the outputs of another.
- R12: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all channels and the interrupt |
| word_i | input | NUM_CH*16 | Received words; channel c at [16c+15:16c] |
| cvalid_i | input | NUM_CH | Control-valid strobe per channel |
| dvalid_i | input | NUM_CH | Data-valid strobe per channel |
| irq_ack_i | input | 1 | One-cycle interrupt acknowledge from host |
| pkt_start_o | output | NUM_CH | Pulses after a command word is accepted |
| pkt_end_o | output | NUM_CH | Pulses after the 17th data-phase word |
| dest_o | output | NUM_CH*2 | Latched destination port per channel |
| cnt_err_o | output | NUM_CH | Sticky short-count flag |
| chk_err_o | output | NUM_CH | Sticky nonzero-residue flag |
| frm_err_o | output | NUM_CH | Sticky stray-data flag |
| irq_o | output | 1 | Error interrupt, held until acknowledged |

## Verification
Two conditions are the hardest to reach from the ports.

1. A corrupted residue that lands exactly in the 17th slot while other channels raise their own events and acknowledges arrive on the same edges.
2. A fresh command that arrives one word short of closure.

The stimulus generator keeps a running XOR for every channel, so that it can form a correct closing word, and flips one bit of that word at random. It also injects early commands, gaps, stray data and acknowledges, so that closures, restarts and acknowledge races fall on the same edges across the four channels. Directed sequences cover each of these cases once on its own before the random run.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_CHECK = 2'd2,
    ST_ERROR = 2'd3
  } pfc_state_e;
endpackage

// File: rtl/pfc_word_class.sv
module pfc_word_class #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              cvalid_i,
  input  logic              dvalid_i,
  output logic              is_cmd_o,
  output logic              is_dat_o
);
  // top bit low marks an opening word; opening wins over data-valid
  assign is_cmd_o = cvalid_i & ~word_i[WORD_W-1];
  assign is_dat_o = dvalid_i & ~is_cmd_o;
endmodule

// File: rtl/pfc_chan.sv
module pfc_chan
  import pfc_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int DEST_W    = 2,
  parameter int PAYLOAD_N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              cvalid_i,
  input  logic              dvalid_i,
  output logic              start_o,
  output logic              end_o,
  output logic [DEST_W-1:0] dest_o,
  output logic              cnt_err_o,
  output logic              chk_err_o,
  output logic              frm_err_o,
  output logic              err_evt_o
);
  localparam int FRAME_N = PAYLOAD_N + 1;
  localparam int CNT_W   = $clog2(FRAME_N + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_N - 1);

  pfc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic [DEST_W-1:0] dest_q;
  logic              start_q, cnt_err_q, chk_err_q, frm_err_q;
  logic              is_cmd, is_dat, in_data, last;
  logic              ev_short, ev_frm, ev_chk;

  pfc_word_class #(.WORD_W(WORD_W)) u_class (
    .word_i  (word_i),
    .cvalid_i(cvalid_i),
    .dvalid_i(dvalid_i),
    .is_cmd_o(is_cmd),
    .is_dat_o(is_dat)
  );

  assign in_data  = (state_q == ST_DATA);
  assign last     = (cnt_q == LAST);
  assign acc_nxt  = acc_q ^ word_i;
  assign ev_short = is_cmd & in_data;
  assign ev_frm   = is_dat & ~in_data;
  assign ev_chk   = is_dat & in_data & last & (acc_nxt != '0);

  always_comb begin
    state_d = in_data ? ST_DATA : ST_IDLE;
    if (is_cmd)                        state_d = ST_DATA;
    else if (is_dat && in_data && last) state_d = ev_chk ? ST_ERROR : ST_CHECK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      acc_q     <= '0;
      dest_q    <= '0;
      start_q   <= 1'b0;
      cnt_err_q <= 1'b0;
      chk_err_q <= 1'b0;
      frm_err_q <= 1'b0;
    end else if (clr_i) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      acc_q     <= '0;
      dest_q    <= '0;
      start_q   <= 1'b0;
      cnt_err_q <= 1'b0;
      chk_err_q <= 1'b0;
      frm_err_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      start_q   <= is_cmd;
      cnt_err_q <= cnt_err_q | ev_short;
      chk_err_q <= chk_err_q | ev_chk;
      frm_err_q <= frm_err_q | ev_frm;
      if (is_cmd) begin
        cnt_q  <= '0;
        acc_q  <= '0;
        dest_q <= word_i[DEST_W-1:0];
      end else if (is_dat && in_data) begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= acc_nxt;
      end
    end
  end

  assign start_o   = start_q;
  assign end_o     = (state_q == ST_CHECK) || (state_q == ST_ERROR);
  assign dest_o    = dest_q;
  assign cnt_err_o = cnt_err_q;
  assign chk_err_o = chk_err_q;
  assign frm_err_o = frm_err_q;
  assign err_evt_o = ev_short | ev_frm | ev_chk;
endmodule

// File: rtl/pfc_irq.sv
module pfc_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              ack_i,
  output logic              irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (clr_i)    irq_q <= 1'b0;
    else if (|evt_i)   irq_q <= 1'b1;  // event beats ack
    else if (ack_i)    irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pkt_frame_chk.sv
module pkt_frame_chk #(
  parameter int NUM_CH    = 4,
  parameter int WORD_W    = 16,
  parameter int DEST_W    = 2,
  parameter int PAYLOAD_N = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic [NUM_CH*WORD_W-1:0] word_i,
  input  logic [NUM_CH-1:0]        cvalid_i,
  input  logic [NUM_CH-1:0]        dvalid_i,
  input  logic                     irq_ack_i,
  output logic [NUM_CH-1:0]        pkt_start_o,
  output logic [NUM_CH-1:0]        pkt_end_o,
  output logic [NUM_CH*DEST_W-1:0] dest_o,
  output logic [NUM_CH-1:0]        cnt_err_o,
  output logic [NUM_CH-1:0]        chk_err_o,
  output logic [NUM_CH-1:0]        frm_err_o,
  output logic                     irq_o
);
  logic [NUM_CH-1:0] evt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pfc_chan #(
      .WORD_W   (WORD_W),
      .DEST_W   (DEST_W),
      .PAYLOAD_N(PAYLOAD_N)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_i),
      .word_i   (word_i[c*WORD_W +: WORD_W]),
      .cvalid_i (cvalid_i[c]),
      .dvalid_i (dvalid_i[c]),
      .start_o  (pkt_start_o[c]),
      .end_o    (pkt_end_o[c]),
      .dest_o   (dest_o[c*DEST_W +: DEST_W]),
      .cnt_err_o(cnt_err_o[c]),
      .chk_err_o(chk_err_o[c]),
      .frm_err_o(frm_err_o[c]),
      .err_evt_o(evt[c])
    );
  end

  pfc_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .evt_i (evt),
    .ack_i (irq_ack_i),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/pkt_frame_chk_sva.sv
module pkt_frame_chk_sva #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic [NUM_CH-1:0] cvalid_i,
  input logic              irq_ack_i,
  input logic [NUM_CH-1:0] pkt_start_o,
  input logic [NUM_CH-1:0] pkt_end_o,
  input logic [NUM_CH-1:0] cnt_err_o,
  input logic [NUM_CH-1:0] chk_err_o,
  input logic [NUM_CH-1:0] frm_err_o,
  input logic              irq_o
);
  AST_START_NEEDS_CVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_start_o & ~$past(cvalid_i)) == '0); // R1

  AST_END_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_o != '0) |=> ((pkt_end_o & $past(pkt_end_o)) == '0)); // R4

  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i && !clr_i) |=> irq_o); // R8

  AST_FLAG_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cnt_err_o & ~$past(cnt_err_o)) | (chk_err_o & ~$past(chk_err_o))
      | (frm_err_o & ~$past(frm_err_o))) != '0) |-> irq_o); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (((cnt_err_o & $past(cnt_err_o)) == $past(cnt_err_o))
             && ((chk_err_o & $past(chk_err_o)) == $past(chk_err_o))
             && ((frm_err_o & $past(frm_err_o)) == $past(frm_err_o)))); // R9

  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_err_o == '0 && chk_err_o == '0 && frm_err_o == '0
               && pkt_start_o == '0 && pkt_end_o == '0 && !irq_o)); // R10
endmodule

bind pkt_frame_chk pkt_frame_chk_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .cvalid_i   (cvalid_i),
  .irq_ack_i  (irq_ack_i),
  .pkt_start_o(pkt_start_o),
  .pkt_end_o  (pkt_end_o),
  .cnt_err_o  (cnt_err_o),
  .chk_err_o  (chk_err_o),
  .frm_err_o  (frm_err_o),
  .irq_o      (irq_o)
);

// File: tb/pkt_frame_chk_bench.sv
module pkt_frame_chk_bench;
  localparam int NCH = 4;
  localparam int WW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic ack = 1'b0;
  logic [WW-1:0]  d_word [NCH];
  logic [NCH-1:0] d_cv = '0, d_dv = '0;
  logic [NCH*WW-1:0] word_flat;
  logic [NCH-1:0] start_o, end_o, cnt_o, chk_o, frm_o;
  logic [NCH*2-1:0] dest_o;
  logic irq;

  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) word_flat[c*WW +: WW] = d_word[c];

  pkt_frame_chk u_pkt_frame_chk (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .word_i(word_flat),
    .cvalid_i(d_cv), .dvalid_i(d_dv), .irq_ack_i(ack),
    .pkt_start_o(start_o), .pkt_end_o(end_o), .dest_o(dest_o),
    .cnt_err_o(cnt_o), .chk_err_o(chk_o), .frm_err_o(frm_o), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  bit             m_in [NCH];
  int             m_cnt [NCH];
  logic [WW-1:0]  m_acc [NCH];
  logic [NCH*2-1:0] m_dest;
  logic [NCH-1:0] m_start, m_end, m_cnt_err, m_chk_err, m_frm_err;
  logic           m_irq;

  // generator state
  int            g_pos [NCH];
  logic [WW-1:0] g_acc [NCH];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic is_cmd_w(logic cv, logic [WW-1:0] w);
    return cv && !w[WW-1];
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_in[c] = 0; m_cnt[c] = 0; m_acc[c] = '0;
    end
    m_dest = '0; m_start = '0; m_end = '0;
    m_cnt_err = '0; m_chk_err = '0; m_frm_err = '0; m_irq = 0;
  endtask

  task automatic model_step();
    logic ev;
    ev = 0;
    if (clr) begin
      model_reset();
      return;
    end
    m_start = '0; m_end = '0;
    for (int c = 0; c < NCH; c++) begin
      logic cmd, dat;
      cmd = is_cmd_w(d_cv[c], d_word[c]);
      dat = d_dv[c] && !cmd;
      if (cmd) begin
        if (m_in[c]) begin m_cnt_err[c] = 1; ev = 1; end
        m_in[c] = 1; m_cnt[c] = 0; m_acc[c] = '0;
        m_dest[c*2 +: 2] = d_word[c][1:0];
        m_start[c] = 1;
      end else if (dat) begin
        if (m_in[c]) begin
          m_acc[c] ^= d_word[c];
          if (m_cnt[c] == 16) begin
            m_end[c] = 1; m_in[c] = 0;
            if (m_acc[c] != '0) begin m_chk_err[c] = 1; ev = 1; end
          end else m_cnt[c]++;
        end else begin
          m_frm_err[c] = 1; ev = 1;
        end
      end
    end
    if (ev) m_irq = 1;
    else if (ack) m_irq = 0;
  endtask

  task automatic compare();
    check("R1 start", 64'(start_o), 64'(m_start));
    check("R2 dest", 64'(dest_o), 64'(m_dest));
    check("R4 end", 64'(end_o), 64'(m_end));
    check("R5 chk_err", 64'(chk_o), 64'(m_chk_err));
    check("R6 cnt_err", 64'(cnt_o), 64'(m_cnt_err));
    check("R7 frm_err", 64'(frm_o), 64'(m_frm_err));
    check("R8 irq", 64'(irq), 64'(m_irq));
  endtask

  // one edge: model tracks the sampled inputs, outputs compared at negedge
  task automatic step();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    if (rst_n) compare();
  endtask

  task automatic idle_in();
    d_cv = '0; d_dv = '0; ack = 0; clr = 0;
    for (int c = 0; c < NCH; c++) d_word[c] = '0;
  endtask

  task automatic drive_cmd(int c, logic [1:0] dst, logic dv);
    d_cv[c] = 1; d_dv[c] = dv;
    d_word[c] = {1'b0, 13'($urandom), dst};
  endtask

  task automatic drive_dat(int c, logic [WW-1:0] w, logic cv);
    d_cv[c] = cv; d_dv[c] = 1; d_word[c] = w;
  endtask

  // send command then n data words; last word forced to close residue if n==17
  task automatic send_pkt(int c, logic [1:0] dst, int n, logic [WW-1:0] flip);
    logic [WW-1:0] x;
    x = '0;
    idle_in(); drive_cmd(c, dst, 1'b1); step();
    for (int i = 0; i < n; i++) begin
      logic [WW-1:0] w;
      idle_in();
      w = (i == 16) ? (x ^ flip) : {1'b1, 15'($urandom)};
      x ^= w;
      drive_dat(c, w, (i == 3)); // cv with top bit set is still data
      step();
    end
    idle_in();
  endtask

  task automatic rand_cycle();
    idle_in();
    ack = ($urandom % 12) == 0;
    clr = ($urandom % 400) == 0;
    for (int c = 0; c < NCH; c++) begin
      int r;
      r = $urandom % 100;
      d_word[c] = WW'($urandom);
      if (g_pos[c] < 0) begin
        if (r < 25) begin
          drive_cmd(c, 2'($urandom), 1'($urandom));
          g_pos[c] = 0; g_acc[c] = '0;
        end else if (r < 29) begin
          d_dv[c] = 1; d_cv[c] = 1'($urandom); d_word[c][WW-1] = 1;
        end else if (r < 35) begin
          d_cv[c] = 1; d_word[c][WW-1] = 1;
        end
      end else begin
        if (r < 4) begin
          drive_cmd(c, 2'($urandom), 1'b0);
          g_pos[c] = 0; g_acc[c] = '0;
        end else if (r < 80) begin
          logic [WW-1:0] w;
          if (g_pos[c] < 16) w = WW'($urandom);
          else w = g_acc[c] ^ ((($urandom % 6) == 0) ? WW'(1) << ($urandom % WW) : '0);
          if (is_cmd_w(1'b1, w)) d_cv[c] = 0;
          d_dv[c] = 1; d_word[c] = w;
          g_acc[c] ^= w;
          g_pos[c]++;
          if (g_pos[c] == 17) g_pos[c] = -1;
        end
      end
    end
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    void'($urandom(32'h5eed_1234));
    idle_in();
    model_reset();
    for (int c = 0; c < NCH; c++) begin g_pos[c] = -1; g_acc[c] = '0; end
    repeat (2) @(negedge clk);
    // R12: outputs quiet during reset
    check("R12 reset outputs", 64'({start_o, end_o, cnt_o, chk_o, frm_o, dest_o, irq}), 64'd0);
    rst_n = 1;
    step();

    // good packet on ch0, command with dv set, one data word with cv and top bit set
    send_pkt(0, 2'd2, 17, '0);
    check("R3 cv+top-bit word counted, packet closed", 64'(end_o[0]), 64'd1);
    check("R4 clean packet no flags", 64'({cnt_o, chk_o, frm_o, irq}), 64'd0);
    check("R11 other channels untouched", 64'(dest_o[7:2]), 64'd0);
    step();
    check("R4 end pulse one cycle", 64'(end_o[0]), 64'd0);

    // corrupt residue on ch1
    send_pkt(1, 2'd1, 17, 16'h0040);
    check("R5 residue error", 64'(chk_o), 64'b0010);
    check("R8 irq on residue error", 64'(irq), 64'd1);
    step();
    ack = 1; step(); idle_in();
    check("R8 ack drops irq", 64'(irq), 64'd0);
    check("R9 flag survives ack", 64'(chk_o[1]), 64'd1);

    // short count on ch2, then restart with new destination
    send_pkt(2, 2'd3, 5, '0);
    drive_cmd(2, 2'd1, 1'b0); step(); idle_in();
    check("R6 short count flag", 64'(cnt_o[2]), 64'd1);
    check("R6 restart start pulse", 64'(start_o[2]), 64'd1);
    check("R6 restart destination", 64'(dest_o[5:4]), 64'd1);
    check("R6 no end on short packet", 64'(end_o[2]), 64'd0);

    // stray data on ch3
    drive_dat(3, 16'hABCD, 1'b0); step(); idle_in();
    check("R7 stray data flag", 64'(frm_o[3]), 64'd1);
    check("R7 stray data no start", 64'(start_o[3]), 64'd0);
    check("R11 ch3 error leaves ch0 clean", 64'({cnt_o[0], chk_o[0], frm_o[0]}), 64'd0);

    // event and ack on same edge: event wins
    ack = 1; drive_dat(3, 16'h8001, 1'b0); step(); idle_in();
    check("R8 event beats ack", 64'(irq), 64'd1);

    clr = 1; step(); idle_in();
    check("R10 clear", 64'({start_o, end_o, cnt_o, chk_o, frm_o, dest_o, irq}), 64'd0);

    for (int i = 0; i < 4000; i++) begin
      rand_cycle();
      step();
      if (clr) for (int c = 0; c < NCH; c++) g_pos[c] = -1;
    end
    idle_in();
    step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule